// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from memory to a MAC transmit path. Software builds a ring of four-word descriptors in memory, each pointing at a word-aligned frame buffer. It hands each descriptor to the engine by setting the descriptor's ownership flag. The engine reads each descriptor in turn and streams the frame one byte at a time to the MAC. It waits for the MAC to report the outcome, writes a status word back into the descriptor and hands the descriptor back to software. It then moves to whichever descriptor the link word names.

A descriptor lives at a 16-byte block starting at address A:

| Address | Contents |
|---|---|
| A+0 | Buffer word. Bit 31 is the owner flag, 1 when the engine owns the descriptor. Bits 30:0 give the buffer address. |
| A+4 | Option word. |
| A+8 | Length and status word. |
| A+12 | Address of the next descriptor. |

The engine stops when it meets a descriptor that software still holds. It can either wait there by re-reading the descriptor, or halt and raise an interrupt.

Software reaches the engine through three registers:

| Address | Register | Access |
|---|---|---|
| 0 | Control | read and write |
| 1 | Ring base | read and write |
| 2 | Current descriptor pointer | read only |

Memory is reached through a single-word request/acknowledge master.

Top module: `tx_ring_dma`

## Requirements
- R1: After reset the engine is idle: mem_req, tx_valid and irq are low, and the control and current-pointer registers read 0.
- R2: A write to register 1 while enable (control bit 0) is clear and the engine is idle loads the current pointer (register 2). While enable is set, such a write leaves the current pointer unchanged.
- R3: When enabled, the engine reads the buffer word at the current pointer. It treats bit 31 = 1 as engine ownership and then reads the option, length and link words at +4, +8 and +12.
- R4: On a descriptor with bit 31 = 0, if control bit 1 (stop interrupt) is set, the engine pulses irq for one cycle, clears control bit 0 and leaves the current pointer on that descriptor.
- R5: On a descriptor with bit 31 = 0 and control bit 1 clear, the engine keeps re-reading the buffer word without any interrupt. It starts the frame once software sets bit 31.
- R6: The engine sends exactly length bytes, taken from bits 15:0 of the +8 word. With option bit 5 set it sends bits 7:0 of each word first; with bit 5 clear it sends bits 31:24 first.
- R7: Option bits 1:0 give the number of leading bytes of the first buffer word to skip. Low address bits 1:0 of the buffer word are ignored for fetching.
- R8: tx_last is high only with the final byte of a frame. tx_no_crc follows option bit 2 and tx_no_pad follows option bit 3 throughout the frame.
- R9: After mac_done, the engine writes the +8 word with the length in bits 15:0, bit 16 = 1 and mac_status in bits 21:17. Only after that does it write the +0 word with bit 31 cleared and bits 30:0 unchanged.
- R10: After write-back the current pointer takes the link word, so the engine follows the links and wraps around the ring wherever the links lead.
- R11: If option bit 4 is set, irq pulses for one cycle after the descriptor is returned. With option bit 4 clear, a completed frame raises no interrupt.
- R12: Writing control with bit 2 set returns the engine to idle and clears enable.
- R13: mem_req, mem_addr and mem_we hold until mem_ack. tx_data holds while tx_valid is high and tx_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 ring base, 2 current pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completion, one cycle; read data valid with it |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Byte available for the MAC |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_no_crc | output | 1 | MAC should not append a CRC to this frame |
| tx_no_pad | output | 1 | MAC should not pad this frame |
| tx_ready | input | 1 | MAC accepts the byte |
| mac_done | input | 1 | MAC has finished the frame |
| mac_status | input | 5 | MAC outcome flags: excess collisions, underrun, no carrier, late collision, FIFO parity |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench uses the default 16-bit length field. This is the width the status write-back places in bits 15:0, so the written status word can be compared directly against a value computed in the bench.

The three descriptors are placed at non-consecutive addresses, so that only link-following reaches them in the expected order. The last link points back to the first descriptor, which closes the ring.

Frames of 3 to 6 bytes are enough to cross a buffer word boundary under every skip count used (0, 1 and 3) and under both byte orders. A MAC that accepts only every other cycle exercises the hold behaviour of the byte stream.

// File: rtl/tx_ring_dma.sv
module tx_ring_dma #(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        tx_no_crc,
  output logic        tx_no_pad,
  input  logic        tx_ready,
  input  logic        mac_done,
  input  logic [4:0]  mac_status,
  output logic        irq
);

  typedef enum logic [3:0] {
    S_IDLE, S_OWN, S_OPT, S_LEN, S_NXT, S_DRD, S_DSND, S_WAIT, S_WST, S_WOWN
  } state_t;

  state_t st;
  logic en, stop_irq, first_q;
  logic [31:0] base_q, cur_q, buf_q, next_q, word_q, waddr;
  logic [5:0] opt_q;
  logic [LEN_W-1:0] len_q, rem_q;
  logic [4:0] stat_q;
  logic [1:0] bidx;

  wire soft_rst = reg_wr && reg_addr == 2'd0 && reg_wdata[2];
  wire [1:0] lane = opt_q[5] ? bidx : ~bidx;

  assign mem_req = st inside {S_OWN, S_OPT, S_LEN, S_NXT, S_DRD, S_WST, S_WOWN};
  assign mem_we  = st inside {S_WST, S_WOWN};
  assign mem_wdata = (st == S_WST)
      ? (32'(len_q) | 32'h0001_0000 | (32'(stat_q) << 17))
      : {1'b0, buf_q[30:0]};

  always_comb begin
    case (st)
      S_OWN, S_WOWN: mem_addr = cur_q;
      S_OPT:         mem_addr = cur_q + 32'd4;
      S_LEN, S_WST:  mem_addr = cur_q + 32'd8;
      S_NXT:         mem_addr = cur_q + 32'd12;
      S_DRD:         mem_addr = waddr;
      default:       mem_addr = 32'd0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {30'd0, stop_irq, en};
      2'd1:    reg_rdata = base_q;
      2'd2:    reg_rdata = cur_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  assign tx_valid  = st == S_DSND;
  assign tx_data   = 8'(word_q >> {lane, 3'b000});
  assign tx_last   = tx_valid && rem_q == LEN_W'(1);
  assign tx_no_crc = opt_q[2];
  assign tx_no_pad = opt_q[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      en <= 1'b0;
      stop_irq <= 1'b0;
      first_q <= 1'b0;
      base_q <= '0;
      cur_q <= '0;
      buf_q <= '0;
      next_q <= '0;
      word_q <= '0;
      waddr <= '0;
      opt_q <= '0;
      len_q <= '0;
      rem_q <= '0;
      stat_q <= '0;
      bidx <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        S_IDLE: if (en) st <= S_OWN;
        S_OWN: if (mem_ack) begin
          if (!en) st <= S_IDLE;
          else if (mem_rdata[31]) begin
            buf_q <= mem_rdata;
            waddr <= {1'b0, mem_rdata[30:2], 2'b00};
            st <= S_OPT;
          end else if (stop_irq) begin
            irq <= 1'b1;
            en <= 1'b0;
            st <= S_IDLE;
          end
        end
        S_OPT: if (mem_ack) begin
          opt_q <= mem_rdata[5:0];
          st <= S_LEN;
        end
        S_LEN: if (mem_ack) begin
          len_q <= mem_rdata[LEN_W-1:0];
          rem_q <= mem_rdata[LEN_W-1:0];
          st <= S_NXT;
        end
        S_NXT: if (mem_ack) begin
          next_q <= mem_rdata;
          first_q <= 1'b1;
          st <= (len_q == '0) ? S_WAIT : S_DRD;
        end
        S_DRD: if (mem_ack) begin
          word_q <= mem_rdata;
          bidx <= first_q ? opt_q[1:0] : 2'd0;
          first_q <= 1'b0;
          st <= S_DSND;
        end
        S_DSND: if (tx_ready) begin
          rem_q <= rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) st <= S_WAIT;
          else if (bidx == 2'd3) begin
            waddr <= waddr + 32'd4;
            st <= S_DRD;
          end else bidx <= bidx + 2'd1;
        end
        S_WAIT: if (mac_done) begin
          stat_q <= mac_status;
          st <= S_WST;
        end
        S_WST: if (mem_ack) st <= S_WOWN;
        S_WOWN: if (mem_ack) begin
          cur_q <= next_q;
          irq <= opt_q[4];
          st <= en ? S_OWN : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase

      if (reg_wr) begin
        case (reg_addr)
          2'd0: begin
            en <= reg_wdata[0] & ~reg_wdata[2];
            stop_irq <= reg_wdata[1];
            if (reg_wdata[2]) st <= S_IDLE;
          end
          2'd1: begin
            base_q <= reg_wdata;
            if (!en && st == S_IDLE) cur_q <= reg_wdata;
          end
          default: ;
        endcase
      end
    end
  end

  p_mem_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !soft_rst |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_tx_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !soft_rst |=> tx_valid && $stable(tx_data));

  p_owner_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_addr == cur_q |-> !mem_wdata[31]);

  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_idle_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && !reg_wr |=> $stable(cur_q));

endmodule

// File: tb/tx_ring_dma_test.sv
module tx_ring_dma_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic tx_valid, tx_last, tx_no_crc, tx_no_pad, tx_ready, mac_done, irq;
  logic [7:0] tx_data;
  logic [4:0] mac_status = 5'd0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic ready_mode = 1'b0;
  logic [31:0] mem [0:255];

  logic [7:0] cap [0:63];
  logic cap_last [0:63];
  logic cap_crc [0:63];
  logic cap_pad [0:63];
  int ncap = 0;
  logic [31:0] wr_addr [0:31];
  logic [31:0] wr_data [0:31];
  int nwr = 0;
  int irq_cnt = 0;
  logic d1;

  tx_ring_dma uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_no_crc(tx_no_crc), .tx_no_pad(tx_no_pad), .tx_ready(tx_ready),
    .mac_done(mac_done), .mac_status(mac_status), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= 32'd0;
      tx_ready <= 1'b0;
      d1 <= 1'b0;
      mac_done <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_we) begin
          mem[mem_addr[9:2]] <= mem_wdata;
          wr_addr[nwr] <= mem_addr;
          wr_data[nwr] <= mem_wdata;
          nwr <= nwr + 1;
        end
      end
      tx_ready <= ready_mode ? ~tx_ready : 1'b1;
      d1 <= tx_valid && tx_ready && tx_last;
      mac_done <= d1;
    end
  end

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && tx_valid && tx_ready) begin
      cap[ncap] <= tx_data;
      cap_last[ncap] <= tx_last;
      cap_crc[ncap] <= tx_no_crc;
      cap_pad[ncap] <= tx_no_pad;
      ncap <= ncap + 1;
    end
    if (rst_n && irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic put_desc(input int a, input logic [31:0] bufw, input logic [31:0] opt,
                          input logic [31:0] len, input logic [31:0] nxt);
    mem[(a+4)>>2] = opt;
    mem[(a+8)>>2] = len;
    mem[(a+12)>>2] = nxt;
    mem[a>>2] = bufw;
  endtask

  task automatic check_frame(input string req, input int start, input int n,
                             input logic [7:0] exp [0:7], input logic crc, input logic pad);
    chk(ncap - start == n, "R6", "byte count", 32'(ncap - start), 32'(n));
    for (int i = 0; i < n; i++) begin
      chk(cap[start+i] == exp[i], req, $sformatf("byte %0d", i), 32'(cap[start+i]), 32'(exp[i]));
      chk(cap_last[start+i] == (i == n-1), "R8", $sformatf("last flag %0d", i),
          32'(cap_last[start+i]), 32'(i == n-1));
      chk(cap_crc[start+i] == crc && cap_pad[start+i] == pad, "R8", "crc/pad flags",
          {30'd0, cap_crc[start+i], cap_pad[start+i]}, {30'd0, crc, pad});
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(!mem_req && !tx_valid && !irq, "R1", "idle outputs", {29'd0, mem_req, tx_valid, irq}, 32'd0);
    rd_reg(2'd0, v); chk(v == 0, "R1", "control", v, 32'd0);
    rd_reg(2'd2, v); chk(v == 0, "R1", "current pointer", v, 32'd0);
  endtask

  task automatic t_stop_irq;
    logic [31:0] v;
    int i0 = irq_cnt;
    put_desc(32'h100, 32'h0000_0201, 0, 0, 32'h140);
    wr_reg(2'd1, 32'h100);
    rd_reg(2'd2, v); chk(v == 32'h100, "R2", "base load", v, 32'h100);
    wr_reg(2'd0, 32'd3);
    repeat (30) @(negedge clk);
    chk(irq_cnt - i0 == 1, "R4", "stop irq count", 32'(irq_cnt - i0), 32'd1);
    rd_reg(2'd0, v); chk(v == 32'd2, "R4", "enable cleared", v, 32'd2);
    rd_reg(2'd2, v); chk(v == 32'h100, "R4", "pointer kept", v, 32'h100);
  endtask

  task automatic t_poll_and_frame_le;
    logic [31:0] v;
    logic [7:0] e [0:7];
    int i0, c0, w0;
    wr_reg(2'd0, 32'd1);
    repeat (30) @(negedge clk);
    i0 = irq_cnt;
    wr_reg(2'd1, 32'h180);
    rd_reg(2'd2, v); chk(v == 32'h100, "R2", "base ignored while enabled", v, 32'h100);
    chk(irq_cnt == i0 && ncap == 0, "R5", "polling silent", 32'(irq_cnt - i0), 32'd0);
    c0 = ncap; w0 = nwr;
    mac_status = 5'b00101;
    mem[32'h200>>2] = 32'h4433_2211;
    mem[32'h204>>2] = 32'h8877_6655;
    mem[32'h140>>2] = 32'h0;
    put_desc(32'h100, 32'h8000_0201, 32'h35, 32'd6, 32'h140);
    repeat (150) @(negedge clk);
    e = '{8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h00, 8'h00};
    check_frame("R7", c0, 6, e, 1'b1, 1'b0);
    chk(nwr - w0 == 2, "R9", "write count", 32'(nwr - w0), 32'd2);
    chk(wr_addr[w0] == 32'h108 && wr_data[w0] == 32'h000B_0006, "R9", "status word first",
        wr_data[w0], 32'h000B_0006);
    chk(wr_addr[w0+1] == 32'h100 && wr_data[w0+1] == 32'h0000_0201, "R9", "owner returned",
        wr_data[w0+1], 32'h0000_0201);
    chk(irq_cnt - i0 == 1, "R11", "frame irq", 32'(irq_cnt - i0), 32'd1);
    rd_reg(2'd2, v); chk(v == 32'h140, "R10", "follow link", v, 32'h140);
  endtask

  task automatic t_frame_be;
    logic [31:0] v;
    logic [7:0] e [0:7];
    int i0 = irq_cnt;
    int c0 = ncap;
    int w0 = nwr;
    ready_mode = 1'b1;
    mac_status = 5'b10010;
    mem[32'h210>>2] = 32'hA1B2_C3D4;
    mem[32'h214>>2] = 32'hE5F6_0718;
    mem[32'h120>>2] = 32'h0;
    put_desc(32'h140, 32'h8000_0210, 32'h00, 32'd5, 32'h120);
    repeat (200) @(negedge clk);
    e = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'h00, 8'h00, 8'h00};
    check_frame("R6", c0, 5, e, 1'b0, 1'b0);
    chk(wr_data[w0] == 32'h0025_0005, "R9", "status with errors", wr_data[w0], 32'h0025_0005);
    chk(irq_cnt == i0, "R11", "no frame irq", 32'(irq_cnt - i0), 32'd0);
    rd_reg(2'd2, v); chk(v == 32'h120, "R10", "non-sequential link", v, 32'h120);
    ready_mode = 1'b0;
    wr_reg(2'd0, 32'd4);
    rd_reg(2'd0, v); chk(v == 0, "R12", "control after soft reset", v, 32'd0);
    repeat (4) @(negedge clk);
    chk(!mem_req, "R12", "idle after soft reset", {31'd0, mem_req}, 32'd0);
    wr_reg(2'd1, 32'h120);
    rd_reg(2'd2, v); chk(v == 32'h120, "R2", "base load after reset", v, 32'h120);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    logic [7:0] e [0:7];
    int i0 = irq_cnt;
    int c0 = ncap;
    int w0 = nwr;
    mac_status = 5'd0;
    mem[32'h220>>2] = 32'hDDCC_BBAA;
    mem[32'h224>>2] = 32'h3322_1100;
    put_desc(32'h120, 32'h8000_0220, 32'h2B, 32'd3, 32'h100);
    wr_reg(2'd0, 32'd3);
    repeat (150) @(negedge clk);
    e = '{8'hDD, 8'h00, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    check_frame("R7", c0, 3, e, 1'b0, 1'b1);
    chk(wr_addr[w0] == 32'h128 && wr_data[w0] == 32'h0001_0003, "R9", "clean status",
        wr_data[w0], 32'h0001_0003);
    chk(irq_cnt - i0 == 1, "R4", "stop at returned descriptor", 32'(irq_cnt - i0), 32'd1);
    rd_reg(2'd2, v); chk(v == 32'h100, "R10", "ring wrap", v, 32'h100);
    rd_reg(2'd0, v); chk(v == 32'd2, "R3", "owner bit honoured", v, 32'd2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_stop_irq;
    t_poll_and_frame_le;
    t_frame_be;
    t_wrap;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule